// File: doc/BRIEF.md
# Two-Cell Pack Protection Controller

This block decides whether the ground-side disconnect switch of a two-cell lithium-ion pack is closed. It also decides whether each cell's bleed path is enabled. It works on comparator flags that have already been digitized: per-cell over-charge and over-discharge, pack undervoltage, charger present, load present, short circuit, and center tap open. The block acts on these flags at the edges where a slow tick strobe is high. The one exception is the short flag, which acts on any clock edge.

The block covers several cases:
- An over-charge with a charger attached must hold for two ticks in a row. A programmable delay then runs before the switch opens, and the over-charged cells are bled while the charger stays attached.
- Deep discharge without a charger puts the block into shutdown.
- Deep discharge with a charger attached gives a 7/8 duty pattern. Pack undervoltage with a charger attached gives a 1/8 duty pattern. An 8-slot tick counter sets both patterns, and the charger is polled during the off slots.
- A short opens the switch at once and latches until the load is gone.
- An open center tap keeps the switch open until the tap reconnects.

Top module: `cellpair_guard`

## Requirements
- R1: Reset puts the block in shutdown: `shutdown`=1, `sw_en`=0, `bleed_en`=0. Shutdown is left only on a tick with `chg_in`=1. A short flag seen while in shutdown keeps the block in shutdown.
- R2: With no fault flags set, a tick puts the block in the normal state, where `sw_en`=1.
- R3: An over-charge (any `cell_ovc` bit) with `chg_in`=1 and `load_in`=0 must be present on 2 consecutive ticks before the delay starts. A tick without this condition restarts the qualification.
- R4: The switch stays closed through the delay. It opens on the `delay_ticks`-th tick after the delay starts, with a minimum of 1. A tick on which the over-charge condition is absent cancels the delay, and the next attempt starts again from qualification.
- R5: Once opened by over-charge, `bleed_en[i]` = `cell_ovc[i]` while `chg_in`=1, and 0 while `chg_in`=0. The switch stays open while the charger is away. The block returns to normal on a tick where no cell is over-charged.
- R6: An over-charge with `load_in`=1 keeps or puts `sw_en`=1 with no bleed. This also applies after the switch has been opened by over-charge.
- R7: An over-discharged cell with `chg_in`=0 sends the block to shutdown on a tick, with the switch open.
- R8: An over-discharged cell with a charger gives a 7/8 duty pattern. The slot number is the count of ticks since reset modulo 8, and `sw_en`=0 only in slot 7. Loss of the charger is acted on only at a tick ending slot 7, and it then leads to shutdown. The block returns to normal on a tick where all cells are normal.
- R9: Pack undervoltage with a charger gives `sw_en`=1 only in slot 0. When undervoltage clears while a cell is still over-discharged, the block moves to the 7/8 pattern.
- R10: `short_in`=1 on any clock edge gives `sw_en`=0 from the next cycle. The switch stays open until a tick where `load_in`=0 and `short_in`=0.
- R11: `tap_open`=1 on a tick opens the switch until a tick where the tap is closed. The exception is undervoltage with a charger, which gives the 1/8 pattern.
- R12: Priority is short first, then open center tap, then undervoltage and cell states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle slow tick strobe |
| delay_ticks | input | DLY_W | Over-charge delay length in ticks |
| cell_ovc | input | 2 | Per-cell over-charge flags |
| cell_ovd | input | 2 | Per-cell over-discharge flags |
| pack_uv | input | 1 | Pack undervoltage flag |
| chg_in | input | 1 | Charger present |
| load_in | input | 1 | Load present |
| short_in | input | 1 | Short-circuit flag |
| tap_open | input | 1 | Center tap open |
| sw_en | output | 1 | Pack switch enable |
| bleed_en | output | 2 | Per-cell bleed enable |
| shutdown | output | 1 | Low-power shutdown indicator |

## Verification
The assertions assume that `tick` is a single-cycle strobe and that every flag is stable around the clock edge. They also assume that `delay_ticks` is held constant while a delay runs. The bench changes every input only at the falling clock edge and raises `tick` for exactly one cycle at a time. It changes `delay_ticks` only between scenarios, while the block is in the normal state. To predict the duty slots, the bench counts ticks from the single reset.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    typedef enum logic [2:0] {
        ST_SHUT   = 3'd0,
        ST_NORM   = 3'd1,
        ST_OCDLY  = 3'd2,
        ST_OCOPEN = 3'd3,
        ST_ODCCHG = 3'd4,
        ST_UVCHG  = 3'd5,
        ST_SHORT  = 3'd6,
        ST_TAP    = 3'd7
    } cpg_state_e;

    typedef struct packed {
        cpg_state_e st;
    } cpg_ctl_t;

endpackage

// File: rtl/cpg_qual.sv
module cpg_qual #(
    parameter int QUAL_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cond,
    output logic met
);
    localparam int CW = (QUAL_TICKS > 1) ? $clog2(QUAL_TICKS) : 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW:0]   nxt;

    always_comb begin
        nxt   = {1'b0, cnt_q} + 1'b1;
        met   = cond && (nxt >= (CW+1)'(QUAL_TICKS));
        cnt_d = cnt_q;
        if (tick) begin
            if (!cond)
                cnt_d = '0;
            else if (!met)
                cnt_d = nxt[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cpg_delay.sv
module cpg_delay #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic [DLY_W-1:0] limit,
    output logic             last
);
    logic [DLY_W-1:0] cnt_d, cnt_q;
    logic [DLY_W:0]   nxt;

    always_comb begin
        nxt   = {1'b0, cnt_q} + 1'b1;
        last  = run && (nxt >= {1'b0, limit});
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (tick && !last)
            cnt_d = nxt[DLY_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cpg_slot.sv
module cpg_slot #(
    parameter int SLOTS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic slot_first,
    output logic slot_last
);
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [SW-1:0] slot_d, slot_q;

    generate
        if (SLOTS == (1 << SW)) begin : g_pow2
            always_comb begin
                slot_d = slot_q;
                if (tick)
                    slot_d = slot_q + 1'b1;
            end
        end else begin : g_wrap
            always_comb begin
                slot_d = slot_q;
                if (tick)
                    slot_d = (slot_q == SW'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
            end
        end
    endgenerate

    assign slot_first = (slot_q == '0);
    assign slot_last  = (slot_q == SW'(SLOTS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            slot_q <= '0;
        else
            slot_q <= slot_d;
    end
endmodule

// File: rtl/cellpair_guard.sv
module cellpair_guard
    import cpg_pkg::*;
#(
    parameter int DLY_W      = 8,
    parameter int QUAL_TICKS = 2,
    parameter int SLOTS      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [DLY_W-1:0] delay_ticks,
    input  logic [1:0]       cell_ovc,
    input  logic [1:0]       cell_ovd,
    input  logic             pack_uv,
    input  logic             chg_in,
    input  logic             load_in,
    input  logic             short_in,
    input  logic             tap_open,
    output logic             sw_en,
    output logic [1:0]       bleed_en,
    output logic             shutdown
);
    cpg_ctl_t   ctl_d, ctl_q;
    cpg_state_e target;
    logic       cond_oc, qual_met, dly_run, dly_last;
    logic       slot_first, slot_last, on_slot, chg_eff;

    assign cond_oc = (|cell_ovc) && chg_in && !load_in;
    assign dly_run = (ctl_q.st == ST_OCDLY) && cond_oc;

    cpg_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cond(cond_oc), .met(qual_met)
    );

    cpg_delay #(.DLY_W(DLY_W)) u_delay (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(dly_run),
        .limit(delay_ticks), .last(dly_last)
    );

    cpg_slot #(.SLOTS(SLOTS)) u_slot (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .slot_first(slot_first), .slot_last(slot_last)
    );

    // During an on slot of a duty pattern the charger is taken as present;
    // it is polled only in the off slots.
    always_comb begin
        on_slot = ((ctl_q.st == ST_ODCCHG) && !slot_last) ||
                  ((ctl_q.st == ST_UVCHG) && slot_first);
        chg_eff = chg_in || on_slot;
    end

    // Tick decision ordered by priority: tap, pack, discharge, charge.
    always_comb begin
        target = ST_NORM;
        if (tap_open)
            target = (pack_uv && chg_eff) ? ST_UVCHG : ST_TAP;
        else if (pack_uv)
            target = chg_eff ? ST_UVCHG : ST_SHUT;
        else if (|cell_ovd)
            target = chg_eff ? ST_ODCCHG : ST_SHUT;
        else if ((|cell_ovc) && !load_in) begin
            if (ctl_q.st == ST_OCOPEN)
                target = ST_OCOPEN;
            else if (chg_in) begin
                if (ctl_q.st == ST_OCDLY)
                    target = dly_last ? ST_OCOPEN : ST_OCDLY;
                else
                    target = qual_met ? ST_OCDLY : ST_NORM;
            end
        end
    end

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_q.st == ST_SHUT) begin
            if (tick && chg_in)
                ctl_d.st = short_in ? ST_SHORT : target;
        end else if (short_in) begin
            ctl_d.st = ST_SHORT;
        end else if (ctl_q.st == ST_SHORT) begin
            if (tick && !load_in)
                ctl_d.st = target;
        end else if (tick) begin
            ctl_d.st = target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl_q <= '{st: ST_SHUT};
        else
            ctl_q <= ctl_d;
    end

    always_comb begin
        sw_en = (ctl_q.st == ST_NORM) || (ctl_q.st == ST_OCDLY) ||
                ((ctl_q.st == ST_ODCCHG) && !slot_last) ||
                ((ctl_q.st == ST_UVCHG) && slot_first);
        bleed_en = cell_ovc & {2{(ctl_q.st == ST_OCOPEN) && chg_in}};
        shutdown = (ctl_q.st == ST_SHUT);
    end
endmodule

// File: rtl/cellpair_guard_chk.sv
module cellpair_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [1:0] cell_ovc,
    input logic       pack_uv,
    input logic       chg_in,
    input logic       short_in,
    input logic       tap_open,
    input logic       sw_en,
    input logic [1:0] bleed_en,
    input logic       shutdown
);
    assert_short_opens_R10: assert property (@(posedge clk) disable iff (!rst_n)
        short_in |=> !sw_en);

    assert_shut_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shutdown) |-> $past(tick && chg_in));

    assert_shut_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (!sw_en && bleed_en == 2'b00));

    assert_bleed_charger_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|bleed_en) |-> (chg_in && !sw_en));

    assert_bleed_cell_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bleed_en & ~cell_ovc) == 2'b00);

    assert_tap_opens_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && tap_open && !pack_uv) |=> !sw_en);
endmodule

bind cellpair_guard cellpair_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cell_ovc(cell_ovc),
    .pack_uv(pack_uv), .chg_in(chg_in), .short_in(short_in),
    .tap_open(tap_open), .sw_en(sw_en), .bleed_en(bleed_en),
    .shutdown(shutdown)
);

// File: tb/cellpair_guard_test.sv
module cellpair_guard_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] delay_ticks = 8'd3;
    logic [1:0] cell_ovc = '0, cell_ovd = '0;
    logic       pack_uv = 0, chg_in = 0, load_in = 0, short_in = 0, tap_open = 0;
    logic       sw_en, shutdown;
    logic [1:0] bleed_en;

    int n_chk = 0, n_err = 0, tick_cnt = 0;

    always #4 clk = ~clk;

    cellpair_guard uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .delay_ticks(delay_ticks),
        .cell_ovc(cell_ovc), .cell_ovd(cell_ovd), .pack_uv(pack_uv),
        .chg_in(chg_in), .load_in(load_in), .short_in(short_in),
        .tap_open(tap_open), .sw_en(sw_en), .bleed_en(bleed_en),
        .shutdown(shutdown)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        tick_cnt++;
    endtask

    task automatic idle();
        cell_ovc = '0; cell_ovd = '0; pack_uv = 0; load_in = 0;
        short_in = 0; tap_open = 0; chg_in = 1;
        do_tick();
        chg_in = 0;
    endtask

    task automatic t_reset();
        chk("R1 shutdown after reset", shutdown, 1);
        chk("R1 switch after reset", sw_en, 0);
        chk("R1 bleed after reset", bleed_en, 0);
        do_tick();
        chk("R1 no exit without charger", shutdown, 1);
        idle();
        chk("R1 exit with charger", shutdown, 0);
        chk("R2 normal switch on", sw_en, 1);
    endtask

    task automatic t_overcharge();
        delay_ticks = 8'd3;
        cell_ovc = 2'b01; chg_in = 1;
        for (int i = 0; i < 4; i++) begin
            do_tick();
            chk("R4 closed during qual and delay", sw_en, 1);
        end
        do_tick();
        chk("R4 opens after delay", sw_en, 0);
        chk("R5 bleed over-charged cell", bleed_en, 1);
        chg_in = 0;
        do_tick();
        chk("R5 bleed off without charger", bleed_en, 0);
        chk("R5 switch stays open", sw_en, 0);
        chg_in = 1; cell_ovc = 2'b11;
        @(negedge clk);
        chk("R5 bleed both cells", bleed_en, 3);
        cell_ovc = 2'b00;
        do_tick();
        chk("R5 back to normal", sw_en, 1);
        chk("R5 bleed released", bleed_en, 0);
        idle();
    endtask

    task automatic t_qual_restart();
        delay_ticks = 8'd1;
        cell_ovc = 2'b01; chg_in = 1;
        do_tick();
        cell_ovc = 2'b00;
        do_tick();
        cell_ovc = 2'b01;
        do_tick();
        do_tick();
        chk("R3 qualification restarted", sw_en, 1);
        do_tick();
        chk("R3 open after requalified", sw_en, 0);
        idle();
        delay_ticks = 8'd3;
        cell_ovc = 2'b10; chg_in = 1;
        for (int i = 0; i < 4; i++) do_tick();
        chg_in = 0;
        do_tick();
        chk("R4 cancelled delay keeps switch", sw_en, 1);
        chg_in = 1;
        for (int i = 0; i < 4; i++) do_tick();
        chk("R4 delay restarted from zero", sw_en, 1);
        do_tick();
        chk("R4 opens after full restart", sw_en, 0);
        idle();
    endtask

    task automatic t_oc_load();
        delay_ticks = 8'd1;
        cell_ovc = 2'b01; chg_in = 1; load_in = 1;
        for (int i = 0; i < 4; i++) do_tick();
        chk("R6 load keeps switch on", sw_en, 1);
        chk("R6 no bleed with load", bleed_en, 0);
        load_in = 0;
        for (int i = 0; i < 3; i++) do_tick();
        chk("R6 open without load", sw_en, 0);
        load_in = 1;
        do_tick();
        chk("R6 load recloses after open", sw_en, 1);
        idle();
    endtask

    task automatic t_odc_duty();
        int pre;
        cell_ovd = 2'b01; chg_in = 1;
        for (int i = 0; i < 16; i++) begin
            do_tick();
            chk("R8 seven-eighths pattern", sw_en, ((tick_cnt % 8) != 7) ? 1 : 0);
        end
        chg_in = 0;
        for (int i = 0; i < 10; i++) begin
            pre = tick_cnt % 8;
            do_tick();
            if (pre == 7) begin
                chk("R8 charger loss in off slot", shutdown, 1);
                break;
            end
            chk("R8 charger loss ignored in on slot", shutdown, 0);
        end
        chg_in = 1;
        do_tick();
        chk("R8 resume duty from shutdown", shutdown, 0);
        cell_ovd = 2'b00;
        do_tick();
        chk("R8 normal when cells normal", sw_en, 1);
        idle();
    endtask

    task automatic t_uv_duty();
        pack_uv = 1; chg_in = 1;
        for (int i = 0; i < 16; i++) begin
            do_tick();
            chk("R9 one-eighth pattern", sw_en, ((tick_cnt % 8) == 0) ? 1 : 0);
        end
        pack_uv = 0; cell_ovd = 2'b10;
        for (int i = 0; i < 3; i++) begin
            do_tick();
            chk("R9 moves to seven-eighths", sw_en, ((tick_cnt % 8) != 7) ? 1 : 0);
        end
        idle();
    endtask

    task automatic t_odc_nochg();
        cell_ovd = 2'b10; chg_in = 0;
        do_tick();
        chk("R7 shutdown on discharge", shutdown, 1);
        chk("R7 switch open", sw_en, 0);
        short_in = 1;
        @(negedge clk);
        short_in = 0;
        @(negedge clk);
        chk("R1 short ignored in shutdown", shutdown, 1);
        cell_ovd = 2'b00;
        do_tick();
        chk("R1 stays shut without charger", shutdown, 1);
        idle();
        chk("R1 leaves with charger", sw_en, 1);
    endtask

    task automatic t_short();
        load_in = 1; short_in = 1;
        @(negedge clk);
        chk("R10 open next cycle", sw_en, 0);
        short_in = 0;
        do_tick();
        chk("R10 held while load present", sw_en, 0);
        load_in = 0;
        do_tick();
        chk("R10 recloses after load removed", sw_en, 1);
        tap_open = 1; short_in = 1;
        @(negedge clk);
        short_in = 0; tap_open = 0; load_in = 1;
        do_tick();
        chk("R12 short over tap", sw_en, 0);
        idle();
        chk("R12 released", sw_en, 1);
    endtask

    task automatic t_tap();
        tap_open = 1; load_in = 1; chg_in = 1;
        do_tick();
        chk("R11 tap opens switch", sw_en, 0);
        do_tick();
        chk("R11 stays open", sw_en, 0);
        pack_uv = 1;
        for (int i = 0; i < 8; i++) begin
            do_tick();
            chk("R11 undervoltage charge with open tap", sw_en, ((tick_cnt % 8) == 0) ? 1 : 0);
        end
        pack_uv = 0;
        do_tick();
        chk("R11 back to open", sw_en, 0);
        tap_open = 0;
        do_tick();
        chk("R11 reconnect closes", sw_en, 1);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_overcharge();
        t_qual_restart();
        t_oc_load();
        t_odc_duty();
        t_uv_duty();
        t_odc_nochg();
        t_short();
        t_tap();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule